// File: doc/BRIEF.md
# Audio Serial Clock Unit

This block produces the three clocks that an I2S or TDM audio port needs when it drives the bus itself: a master clock, a serial bit clock and a frame sync. All three come from one reference clock. It also gives the serializers two single-cycle strobes in the reference domain: one at the start of each frame and one at the start of each slot. Two encoded fields set the frame shape: the slot count and the slot width. Two divider fields set the master clock rate and the bit clock rate. The bit clock rate must equal the sample rate times the slots per frame times the bits per slot. For example, 6 slots of 32 bits at 48 kHz need 9.216 MHz.

The configuration is sampled while the unit is idle and frozen while it runs. It must be stable for at least two reference cycles before enable rises. The unit runs without any serializer attached. When enable drops, the unit finishes the frame in progress and stops at the next frame boundary. It does not cut the bit stream short.

Top module: `audio_sclk_unit`

## Requirements
- R1: While the unit is stopped, mck_o, sck_o, fs_o, frame_start_o and slot_start_o are all low. This includes the state after reset.
- R2: With cfg_sck_div = D > 0 and N = D+1, sck_o has a period of N reference cycles. It is high for the first floor(N/2) cycles of each period. The first period begins at the second rising reference edge that samples enable high.
- R3: With cfg_sck_div = 0, sck_o is the inverted reference clock while the unit runs. Each falling edge of sck_o is therefore a rising reference edge.
- R4: cfg_mck_div follows the same rule for mck_o (period cfg_mck_div+1, high for the first floor(period/2) cycles). With cfg_mck_div = 0, mck_o is the reference clock passed through unchanged.
- R5: A frame is (cfg_slots_m1+1) slots long. Each slot is W bit clocks long, where slot-size codes 0, 1, 2 and 3 give W = 8, 16, 24 and 32.
- R6: fs_o is high during every bit of the first slot and low during every other slot. It changes only on a reference edge where sck_o falls.
- R7: frame_start_o pulses for exactly one reference cycle after the sck_o falling edge that begins bit 0 of slot 0. slot_start_o pulses the same way after the falling edge that begins bit 0 of any slot.
- R8: After enable drops, the unit keeps running until the current frame is complete. It stops at the sck_o falling edge that would begin the next frame. If no frame has begun yet, it stops at the first falling edge. From that edge on, sck_o, fs_o and both strobes are low, and mck_o is low one cycle later.
- R9: Changes to the cfg_* inputs while the unit runs have no effect until it has stopped.
- R10: Each start resets the divider and slot counters. A second run with the same configuration reproduces the first run cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; a drop causes a graceful stop at the next frame boundary |
| cfg_slots_m1 | input | SLOT_CNT_W | Slots per frame minus one |
| cfg_slot_size | input | 2 | Slot width code: 0=8, 1=16, 2=24, 3=32 bits |
| cfg_mck_div | input | DIV_W | Master clock divide minus one |
| cfg_sck_div | input | DIV_W | Bit clock divide minus one |
| mck_o | output | 1 | Master clock output |
| sck_o | output | 1 | Serial bit clock output |
| fs_o | output | 1 | Frame sync, high during the first slot |
| frame_start_o | output | 1 | One-cycle strobe at the start of each frame |
| slot_start_o | output | 1 | One-cycle strobe at the start of each slot |

## Verification
The bench compares every output on every cycle against a model built from cycle counts. It targets several corner cases:
- **Pass-through dividers.** It samples both clock phases. An inverted or missing bypass would show a stuck level instead of the reference clock.
- **Odd divide ratios.** A wrong duty split would move the sck falling edge, and with it every fs and strobe transition.
- **Single-slot and maximum-length frames.** An off-by-one in the slot or bit wrap would shift frame_start by a slot or a bit.
- **Disable timing.** It drops enable before the first bit, in mid-frame and right at a boundary. A design that stops at once, or one frame late, would disagree on the stop cycle.
- **Configuration changes while running.** Changing the cfg_* inputs mid-run would expose a design that reads live configuration.
- **Repeated runs.** Repeating a run would expose counters that are not re-armed on enable.

// File: rtl/asu_pkg.sv
package asu_pkg;
   localparam int BIT_W = 5;

   typedef enum logic [1:0] {
      SZ_8  = 2'd0,
      SZ_16 = 2'd1,
      SZ_24 = 2'd2,
      SZ_32 = 2'd3
   } slot_size_e;

   // last bit index inside a slot: 8*(code+1)-1
   function automatic logic [BIT_W-1:0] slot_last_bit(input logic [1:0] code);
      logic [BIT_W-1:0] w;
      w = ({3'b000, code} + 5'd1) << 3;
      return w - 5'd1;
   endfunction
endpackage

// File: rtl/asu_clk_div.sv
module asu_clk_div #(
   parameter int DIV_W       = 8,
   parameter bit BYPASS_INV  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             clk_o,
   output logic             fall_o
);
   localparam int CW = DIV_W + 1;

   logic [DIV_W-1:0] cnt_q, cnt_n;
   logic [CW-1:0]    half;
   logic             hi_n, q, bypass;

   generate
      if (DIV_W < 1) begin : g_bad_w
         $error("asu_clk_div: DIV_W must be at least 1");
      end
   endgenerate

   assign bypass = (div == '0);
   assign half   = ({1'b0, div} + CW'(1)) >> 1;
   assign cnt_n  = (cnt_q == div) ? '0 : cnt_q + DIV_W'(1);
   assign hi_n   = ({1'b0, cnt_n} < half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         q     <= 1'b0;
      end else if (!run) begin
         cnt_q <= div;
         q     <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         q     <= hi_n;
      end
   end

   assign fall_o = run & (bypass | (q & ~hi_n));

   generate
      if (BYPASS_INV) begin : g_inv
         assign clk_o = bypass ? (run & ~clk) : q;
      end else begin : g_pass
         assign clk_o = bypass ? (run & clk) : q;
      end
   endgenerate

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= div)); // R2
   AST_DIV_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> !q); // R1
endmodule

// File: rtl/asu_frame_seq.sv
module asu_frame_seq #(
   parameter int SLOT_CNT_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  adv,
   input  logic [SLOT_CNT_W-1:0] slots_m1,
   input  logic [1:0]            size_code,
   output logic                  frame_last,
   output logic                  fs,
   output logic                  frame_start,
   output logic                  slot_start
);
   import asu_pkg::*;

   logic [BIT_W-1:0]      bit_q, bit_n, bits_m1;
   logic [SLOT_CNT_W-1:0] slot_q, slot_n;
   logic                  slot_end;

   assign bits_m1    = slot_last_bit(size_code);
   assign slot_end   = (bit_q == bits_m1);
   assign frame_last = slot_end && (slot_q == slots_m1);
   assign bit_n      = slot_end ? '0 : bit_q + BIT_W'(1);
   assign slot_n     = !slot_end ? slot_q :
                       (slot_q == slots_m1) ? '0 : slot_q + SLOT_CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= '0; slot_q <= '0;
         fs <= 1'b0; frame_start <= 1'b0; slot_start <= 1'b0;
      end else if (clear) begin
         bit_q <= bits_m1; slot_q <= slots_m1;
         fs <= 1'b0; frame_start <= 1'b0; slot_start <= 1'b0;
      end else begin
         frame_start <= 1'b0;
         slot_start  <= 1'b0;
         if (adv) begin
            bit_q       <= bit_n;
            slot_q      <= slot_n;
            fs          <= (slot_n == '0);
            frame_start <= (bit_n == '0) && (slot_n == '0);
            slot_start  <= (bit_n == '0);
         end
      end
   end

   AST_FRAME_IS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (slot_start && fs)); // R7
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start); // R7
   AST_BIT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |-> (bit_q <= bits_m1)); // R5
endmodule

// File: rtl/audio_sclk_unit.sv
module audio_sclk_unit #(
   parameter int DIV_W      = 8,
   parameter int SLOT_CNT_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic [SLOT_CNT_W-1:0] cfg_slots_m1,
   input  logic [1:0]            cfg_slot_size,
   input  logic [DIV_W-1:0]      cfg_mck_div,
   input  logic [DIV_W-1:0]      cfg_sck_div,
   output logic                  mck_o,
   output logic                  sck_o,
   output logic                  fs_o,
   output logic                  frame_start_o,
   output logic                  slot_start_o
);
   typedef struct packed {
      logic [SLOT_CNT_W-1:0] slots_m1;
      logic [1:0]            size;
      logic [DIV_W-1:0]      mck_div;
      logic [DIV_W-1:0]      sck_div;
   } cfg_t;

   generate
      if (SLOT_CNT_W < 1 || SLOT_CNT_W > 8) begin : g_bad_slots
         $error("audio_sclk_unit: SLOT_CNT_W out of range");
      end
   endgenerate

   cfg_t cfg_q;
   logic run_q, sck_fall, frame_last, stop, mck_fall_unused;

   assign stop = run_q & sck_fall & frame_last & ~enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cfg_q <= '0;
      end else begin
         if (!run_q)
            cfg_q <= '{slots_m1: cfg_slots_m1, size: cfg_slot_size,
                       mck_div: cfg_mck_div, sck_div: cfg_sck_div};
         if (!run_q)
            run_q <= enable;
         else if (stop)
            run_q <= 1'b0;
      end
   end

   asu_clk_div #(.DIV_W(DIV_W), .BYPASS_INV(1'b0)) u_mck (
      .clk(clk), .rst_n(rst_n), .run(run_q), .div(cfg_q.mck_div),
      .clk_o(mck_o), .fall_o(mck_fall_unused));

   asu_clk_div #(.DIV_W(DIV_W), .BYPASS_INV(1'b1)) u_sck (
      .clk(clk), .rst_n(rst_n), .run(run_q), .div(cfg_q.sck_div),
      .clk_o(sck_o), .fall_o(sck_fall));

   asu_frame_seq #(.SLOT_CNT_W(SLOT_CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .clear(~run_q | stop), .adv(sck_fall),
      .slots_m1(cfg_q.slots_m1), .size_code(cfg_q.size),
      .frame_last(frame_last), .fs(fs_o),
      .frame_start(frame_start_o), .slot_start(slot_start_o));

   AST_FS_ON_SCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_o != $past(fs_o)) |-> $past(sck_fall)); // R6
   AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> ($past(frame_last) && !$past(enable))); // R8
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q)) |-> $stable(cfg_q)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_q) |-> (!fs_o && !frame_start_o && !slot_start_o)); // R1
endmodule

// File: tb/tb_audio_sclk_unit.sv
module tb_audio_sclk_unit;
   localparam int DIV_W = 8;
   localparam int SLOT_CNT_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic [SLOT_CNT_W-1:0] cfg_slots_m1 = '0;
   logic [1:0]            cfg_slot_size = '0;
   logic [DIV_W-1:0]      cfg_mck_div = '0;
   logic [DIV_W-1:0]      cfg_sck_div = '0;
   logic mck_o, sck_o, fs_o, frame_start_o, slot_start_o;

   int n_tests = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   audio_sclk_unit #(.DIV_W(DIV_W), .SLOT_CNT_W(SLOT_CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_slots_m1(cfg_slots_m1), .cfg_slot_size(cfg_slot_size),
      .cfg_mck_div(cfg_mck_div), .cfg_sck_div(cfg_sck_div),
      .mck_o(mck_o), .sck_o(sck_o), .fs_o(fs_o),
      .frame_start_o(frame_start_o), .slot_start_o(slot_start_o));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got %0d cycles expected below 190000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input string what, input int got, input int exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d (t=%0d)", tag, what, got, exp, cyc);
      end
   endtask

   function automatic int exp_clk(input int div_p1, input int t);
      if (div_p1 == 1) return -1;
      if (t < 1) return 0;
      return (((t - 1) % div_p1) < (div_p1 / 2)) ? 1 : 0;
   endfunction

   task automatic run_case(input int sm1, input int sz, input int md, input int sd,
                           input int drop_t, input bit scramble, input string tg);
      int n, hf, m, w, fb, k, cur, t_stop;
      bit stopped, fs_e, fst_e, sst_e;
      @(posedge clk); #1;
      cfg_slots_m1 = SLOT_CNT_W'(sm1); cfg_slot_size = 2'(sz);
      cfg_mck_div = DIV_W'(md); cfg_sck_div = DIV_W'(sd);
      repeat (3) @(posedge clk);
      #1 enable = 1'b1;
      n = sd + 1; hf = n / 2; m = md + 1;
      w = (sz + 1) * 8; fb = w * (sm1 + 1);
      stopped = 0; t_stop = -1; fs_e = 0;
      for (int t = 0; t < 40000; t++) begin
         @(posedge clk); #1;
         fst_e = 0; sst_e = 0;
         if (!stopped && t >= 1 + hf && ((t - 1 - hf) % n) == 0) begin
            k = (t - 1 - hf) / n;
            if ((k % fb) == 0 && t > drop_t) begin
               stopped = 1; t_stop = t; fs_e = 0;
            end else begin
               cur = k % fb;
               fs_e = (cur < w); fst_e = (cur == 0); sst_e = ((cur % w) == 0);
            end
         end
         if (!stopped) begin
            chk({tg, "/R2/R3"}, "sck", int'(sck_o), (n == 1) ? 0 : exp_clk(n, t));
            chk({tg, "/R4"}, "mck", int'(mck_o), (m == 1) ? 1 : exp_clk(m, t));
            chk({tg, "/R6"}, "fs", int'(fs_o), int'(fs_e));
            chk({tg, "/R5/R7"}, "frame_start", int'(frame_start_o), int'(fst_e));
            chk({tg, "/R7"}, "slot_start", int'(slot_start_o), int'(sst_e));
            if (t == 2 && (n == 1 || m == 1)) begin
               @(negedge clk); #1;
               if (n == 1) chk({tg, "/R3"}, "sck low phase", int'(sck_o), 1);
               if (m == 1) chk({tg, "/R4"}, "mck low phase", int'(mck_o), 0);
            end
         end else begin
            chk({tg, "/R8"}, "sck stopped", int'(sck_o), 0);
            chk({tg, "/R8"}, "fs stopped", int'(fs_o), 0);
            chk({tg, "/R8"}, "strobes stopped", int'(frame_start_o | slot_start_o), 0);
            if (m == 1 || t > t_stop) chk({tg, "/R8"}, "mck stopped", int'(mck_o), 0);
         end
         if (t == drop_t) enable = 1'b0;
         if (scramble && t == 3) begin
            cfg_slots_m1 = SLOT_CNT_W'($urandom); cfg_slot_size = 2'($urandom);
            cfg_mck_div = DIV_W'($urandom_range(0, 6));
            cfg_sck_div = DIV_W'($urandom_range(0, 6));
         end
         if (stopped && t >= t_stop + 4) break;
      end
      chk({tg, "/R8"}, "unit stopped", int'(stopped), 1);
   endtask

   initial begin
      void'($urandom(32'h5EED_0A11));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1", "mck reset", int'(mck_o), 0);
      chk("R1", "sck reset", int'(sck_o), 0);
      chk("R1", "fs reset", int'(fs_o), 0);
      chk("R1", "strobes reset", int'(frame_start_o | slot_start_o), 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1 chk("R1", "sck idle", int'(sck_o), 0);
      chk("R1", "mck idle", int'(mck_o), 0);

      // 6 slots of 32 bits, mck = ref, sck = ref/2, two frames
      run_case(5, 3, 0, 1, 700, 1'b0, "R5");
      // 1 slot of 8 bits, both dividers bypassed
      run_case(0, 0, 0, 0, 30, 1'b0, "R3");
      // disable before the first bit begins
      run_case(2, 1, 3, 2, 0, 1'b0, "R8");
      // odd divide ratios, mid-frame drop
      run_case(3, 2, 4, 4, 333, 1'b0, "R2");
      // restart with identical configuration
      run_case(1, 0, 2, 2, 100, 1'b0, "R10");
      run_case(1, 0, 2, 2, 100, 1'b0, "R10");
      // config changes while running
      run_case(2, 1, 1, 3, 250, 1'b1, "R9");

      for (int i = 0; i < 14; i++) begin
         int sm1, sz, md, sd, fr;
         sm1 = $urandom_range(0, 7); sz = $urandom_range(0, 3);
         md = $urandom_range(0, 4); sd = $urandom_range(0, 4);
         fr = (sm1 + 1) * (sz + 1) * 8 * (sd + 1);
         run_case(sm1, sz, md, sd, $urandom_range(0, fr * 2), 1'($urandom), "R9/R10");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule